// File: doc/BRIEF.md
# Fine-Step Scale Factor Calibrator

This block measures how many fine delay steps of an external delay line fit into one coarse PWM clock period, and publishes that number as a scale factor. The conversion logic of every high-resolution PWM channel reads the scale factor. The block runs on the PWM clock and works independently of the channels, so a calibration can be started at any moment while the channels keep running. There is no minimum spacing between runs.

A run begins with a one-cycle start strobe. The run then takes a fixed number of measurement windows. In each window the delay-line model supplies a tap snapshot together with a valid strobe. For each snapshot the block counts the set taps that precede the first clear one. It then averages the window counts and checks them against the legal range. A good result is loaded into the scale register. An out-of-range result raises an error code, and the register keeps its last good value. The status code reads 0 while a run is in progress, 1 after a good run and 2 after a failed run. A finished code is held until the next start strobe.

Top module: `sfc_scale_cal`

## Requirements
- R1: After reset, `scale_factor` is 66, `cal_status` is 0 and `busy` is 0.
- R2: A start strobe sampled while idle sets `busy` to 1 and `cal_status` to 0 at the next clock edge. While `busy` is 1, `cal_status` reads 0.
- R3: A window's step count is the number of consecutive set taps starting at tap 0. Taps above the first clear tap have no effect on the count.
- R4: A run uses N_WIN windows (4 by default). One clock edge after the edge that accepts the last window, `busy` falls. If the run is good, `cal_status` becomes 1 and `scale_factor` takes the floor of the mean of the window counts.
- R5: A window count of 0, or a count above 255 (all 256 taps set), makes the run fail. The run then ends with `cal_status` = 2 and `scale_factor` unchanged.
- R6: A start strobe that arrives while a run is in progress is ignored. The run neither restarts nor ends early.
- R7: A status of 1 or 2 is held until the next accepted start strobe. That strobe clears the status to 0.
- R8: Snapshot strobes that arrive while the block is idle are ignored and have no effect on the status, the scale factor or the next run.
- R9: A count of exactly 255 is legal, so a run of four 255-step windows gives a scale factor of 255.
- R10: A start strobe sampled at the edge right after a run completes is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | One-cycle request to begin a calibration run |
| win_valid | input | 1 | Tap snapshot is present this cycle |
| win_taps | input | NTAPS (256) | Sampled tap vector; bit 0 is the first tap |
| busy | output | 1 | A calibration run is in progress |
| cal_status | output | 2 | 0 = running or cleared, 1 = new factor loaded, 2 = out of range |
| scale_factor | output | SW (8) | Published fine steps per coarse period |

## Verification
The `busy` and `cal_status` responses to an accepted start strobe are due one edge after that strobe, so the bench samples them at the very next falling edge. The result of a run, whether a code and a new factor or a code and the old factor, is due one edge after the last window is accepted. The monitor compares it against the queued expectation at the falling edge where `busy` is first seen low. Ignored stimuli, such as idle snapshots and mid-run strobes, are checked by reading the held status and factor after the stimulus. They are also checked through the result of the following run, which must match a model that never saw those stimuli.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    CAL_RUN  = 2'd0,
    CAL_DONE = 2'd1,
    CAL_FAIL = 2'd2
  } cal_status_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_MEAS   = 2'd1,
    SQ_FINISH = 2'd2
  } seq_state_e;

  // legal window count: at least one step, at most max_steps
  function automatic logic count_in_range(logic [31:0] cnt, logic [31:0] max_steps);
    return (cnt != 32'd0) && (cnt <= max_steps);
  endfunction

  // floor of the mean when the window count is a power of two
  function automatic logic [31:0] mean_floor(logic [31:0] sum, int unsigned shift);
    return sum >> shift;
  endfunction

endpackage

// File: rtl/sfc_tap_encoder.sv
module sfc_tap_encoder #(
  parameter int NTAPS = 256,
  parameter int CW    = $clog2(NTAPS + 1)
) (
  input  logic [NTAPS-1:0] taps,
  output logic [CW-1:0]    step_count
);

  // prefix-AND chain: run_ok[i] is set while every tap up to i is set
  logic [NTAPS-1:0] run_ok;

  assign run_ok[0] = taps[0];
  for (genvar gi = 1; gi < NTAPS; gi++) begin : g_chain
    assign run_ok[gi] = run_ok[gi-1] & taps[gi];
  end

  always_comb begin
    step_count = '0;
    for (int i = 0; i < NTAPS; i++) begin
      step_count = step_count + CW'(run_ok[i]);
    end
  end

  always_comb begin
    a_count_bound_r3 : assert (step_count <= CW'(NTAPS));
  end

endmodule

// File: rtl/sfc_accum.sv
module sfc_accum #(
  parameter int CW        = 9,
  parameter int N_WIN     = 4,
  parameter int MAX_STEPS = 255,
  localparam int WL       = $clog2(N_WIN),
  localparam int IW       = WL + 1,
  localparam int SUMW     = CW + WL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            take,
  input  logic [CW-1:0]   step_count,
  output logic [SUMW-1:0] acc_sum,
  output logic            bad_seen,
  output logic            win_bad,
  output logic            last_take
);

  import sfc_pkg::*;

  logic [IW-1:0] win_idx;

  assign win_bad   = take && !count_in_range(32'(step_count), 32'(MAX_STEPS));
  assign last_take = take && (win_idx == IW'(N_WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sum  <= '0;
      win_idx  <= '0;
      bad_seen <= 1'b0;
    end else if (clear) begin
      acc_sum  <= '0;
      win_idx  <= '0;
      bad_seen <= 1'b0;
    end else if (take) begin
      acc_sum  <= acc_sum + SUMW'(step_count);
      win_idx  <= last_take ? '0 : win_idx + 1'b1;
      bad_seen <= bad_seen | win_bad;
    end
  end

  p_idx_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    win_idx < IW'(N_WIN));

  p_bad_sticky_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (win_bad && !clear) |=> bad_seen);

endmodule

// File: rtl/sfc_seq.sv
module sfc_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_start,
  input  logic       win_valid,
  input  logic       last_take,
  input  logic       bad_seen,
  input  logic       win_bad,
  output logic       busy,
  output logic [1:0] cal_status,
  output logic       clear,
  output logic       take,
  output logic       commit
);

  import sfc_pkg::*;

  seq_state_e state;
  logic       start_acc;
  logic       finish_evt;
  logic       run_bad;

  assign start_acc  = (state == SQ_IDLE) && cal_start;
  assign take       = (state == SQ_MEAS) && win_valid;
  assign clear      = start_acc;
  assign finish_evt = (state == SQ_FINISH);
  assign run_bad    = bad_seen;
  assign commit     = finish_evt && !run_bad;
  assign busy       = (state != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      cal_status <= CAL_RUN;
    end else begin
      case (state)
        SQ_IDLE: if (start_acc) begin
          state      <= SQ_MEAS;
          cal_status <= CAL_RUN;
        end
        SQ_MEAS: if (last_take) state <= SQ_FINISH;
        SQ_FINISH: begin
          state      <= SQ_IDLE;
          cal_status <= run_bad ? CAL_FAIL : CAL_DONE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  p_busy_run_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cal_status == CAL_RUN));

  p_start_clears_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && cal_status == CAL_RUN));

  p_start_ignored_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_MEAS && !last_take) |=> (state == SQ_MEAS));

  p_status_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (cal_status != CAL_RUN && !start_acc) |=> $stable(cal_status));

  p_fail_code_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (finish_evt && run_bad) |=> (cal_status == CAL_FAIL));

  p_idle_ignore_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cal_start) |=> !busy);

  p_no_bad_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !win_bad);

endmodule

// File: rtl/sfc_scale_cal.sv
module sfc_scale_cal #(
  parameter int NTAPS       = 256,
  parameter int SW          = 8,
  parameter int N_WIN       = 4,
  parameter int RESET_SCALE = 66,
  localparam int CW         = $clog2(NTAPS + 1),
  localparam int WL         = $clog2(N_WIN),
  localparam int SUMW       = CW + WL,
  localparam int MAX_STEPS  = (1 << SW) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic             win_valid,
  input  logic [NTAPS-1:0] win_taps,
  output logic             busy,
  output logic [1:0]       cal_status,
  output logic [SW-1:0]    scale_factor
);

  import sfc_pkg::*;

  logic [CW-1:0]   step_count;
  logic [SUMW-1:0] acc_sum;
  logic            bad_seen;
  logic            win_bad;
  logic            last_take;
  logic            clear;
  logic            take;
  logic            commit;
  logic [SW-1:0]   mean_val;

  sfc_tap_encoder #(.NTAPS(NTAPS), .CW(CW)) u_enc (
    .taps       (win_taps),
    .step_count (step_count)
  );

  sfc_accum #(.CW(CW), .N_WIN(N_WIN), .MAX_STEPS(MAX_STEPS)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .take       (take),
    .step_count (step_count),
    .acc_sum    (acc_sum),
    .bad_seen   (bad_seen),
    .win_bad    (win_bad),
    .last_take  (last_take)
  );

  sfc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_start  (cal_start),
    .win_valid  (win_valid),
    .last_take  (last_take),
    .bad_seen   (bad_seen),
    .win_bad    (win_bad),
    .busy       (busy),
    .cal_status (cal_status),
    .clear      (clear),
    .take       (take),
    .commit     (commit)
  );

  assign mean_val = SW'(mean_floor(32'(acc_sum), WL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      scale_factor <= SW'(RESET_SCALE);
    else if (commit) scale_factor <= mean_val;
  end

  p_scale_commit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (scale_factor != $past(scale_factor)) |-> (cal_status == CAL_DONE));

  p_scale_nonzero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (scale_factor != '0));

endmodule

// File: tb/sim_sfc_scale_cal.sv
module sim_sfc_scale_cal;

  localparam int NT = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_start = 1'b0;
  logic          win_valid = 1'b0;
  logic [NT-1:0] win_taps = '0;
  logic          busy;
  logic [1:0]    cal_status;
  logic [7:0]    scale_factor;

  int checks = 0;
  int errors = 0;
  int model_scale = 66;
  int q_status[$];
  int q_scale[$];
  bit done_all = 1'b0;

  always #2.5 clk = ~clk;

  sfc_scale_cal u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_start    (cal_start),
    .win_valid    (win_valid),
    .win_taps     (win_taps),
    .busy         (busy),
    .cal_status   (cal_status),
    .scale_factor (scale_factor)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // n set taps from tap 0, a clear tap, then a noise pattern above
  function automatic logic [NT-1:0] mk_taps(input int n);
    logic [NT-1:0] v;
    for (int i = 0; i < NT; i++) begin
      if (i < n)       v[i] = 1'b1;
      else if (i == n) v[i] = 1'b0;
      else             v[i] = (i % 3 == 0);
    end
    return v;
  endfunction

  task automatic run_cal(input int c0, input int c1, input int c2, input int c3,
                         input bit mid_start);
    int cs[4];
    int sum;
    bit bad;
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
    sum = 0; bad = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sum += cs[k];
      if (cs[k] < 1 || cs[k] > 255) bad = 1'b1;
    end
    if (bad) q_status.push_back(2);
    else begin
      q_status.push_back(1);
      model_scale = sum / 4;
    end
    q_scale.push_back(model_scale);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(cal_status == 2'd0, "R7 status cleared by start", cal_status, 0);
    for (int k = 0; k < 4; k++) begin
      win_valid = 1'b1;
      win_taps  = mk_taps(cs[k]);
      if (mid_start && k == 2) cal_start = 1'b1;
      @(negedge clk);
      win_valid = 1'b0;
      cal_start = 1'b0;
      if (k == 1) @(negedge clk);
    end
    while (busy) @(negedge clk);
  endtask

  // monitor: compare each completed run with the queued expectation
  initial begin
    logic prev_busy;
    prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_busy && !busy) begin
        if (q_status.size() == 0) begin
          chk(1'b0, "R4 unexpected completion", 1, 0);
        end else begin
          int es, ev;
          es = q_status.pop_front();
          ev = q_scale.pop_front();
          chk(cal_status == 2'(es), "R4/R5 status code", cal_status, es);
          chk(scale_factor == 8'(ev), "R4/R5 scale factor", scale_factor, ev);
        end
      end
      prev_busy = busy;
    end
  end

  // watchdog
  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done_all) break;
    end
    if (!done_all) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(scale_factor == 8'd66, "R1 reset scale", scale_factor, 66);
    chk(cal_status == 2'd0, "R1 reset status", cal_status, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: mean of 60,66,70,72 = 67, noise above the first clear tap
    run_cal(60, 66, 70, 72, 1'b0);

    // R8: idle snapshots are ignored
    for (int k = 0; k < 3; k++) begin
      win_valid = 1'b1;
      win_taps  = mk_taps(3);
      @(negedge clk);
    end
    win_valid = 1'b0;
    chk(busy == 1'b0, "R8 idle snapshot starts nothing", busy, 0);
    chk(cal_status == 2'd1, "R8 status kept", cal_status, 1);
    chk(scale_factor == 8'd67, "R8 scale kept", scale_factor, 67);

    // R6: mid-run start ignored; 406/4 = 101
    run_cal(100, 101, 102, 103, 1'b1);

    // R5: above range (all taps set gives 256)
    run_cal(50, 256, 50, 50, 1'b0);
    repeat (5) @(negedge clk);
    chk(cal_status == 2'd2, "R7 fail code held", cal_status, 2);
    chk(scale_factor == 8'd101, "R5 scale kept on error", scale_factor, 101);

    // R5: zero count
    run_cal(0, 80, 80, 80, 1'b0);

    // R9 boundary, then R10 immediate restart
    run_cal(255, 255, 255, 255, 1'b0);
    run_cal(255, 254, 255, 255, 1'b0);
    chk(scale_factor == 8'd254, "R10 back-to-back result", scale_factor, 254);

    // R3: single-tap runs; 1,2,1,2 -> 1
    run_cal(1, 2, 1, 2, 1'b0);
    repeat (2) @(negedge clk);
    chk(q_status.size() == 0, "R4 all results seen", q_status.size(), 0);
    chk(cal_status == 2'd1, "R7 done code held", cal_status, 1);

    done_all = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule